// File: doc/BRIEF.md
# Transmit FIFO Flush Controller

This block sits between a transmit DMA front end and a MAC transmitter. It holds a small byte FIFO whose entries carry start-of-frame and end-of-frame sideband bits, and it carries out a flush that software requests. When software sets the flush bit, the FIFO is emptied on the same clock edge, even while the MAC is in the middle of taking a frame. If a frame was partly handed to the MAC, that frame is aborted as an underflow and a 32-bit status word is offered on a valid/ready port. The word carries both the underflow flag and the flushed flag. The flush bit clears itself once the operation has finished.

After a flush, incoming bytes from the DMA side are accepted and thrown away until a byte marked as the start of a frame arrives. Storage resumes from that byte. This keeps the tail of a half-fetched frame from reaching the MAC.

Top module: `tx_fifo_flush`

## Requirements
- R1: A cycle with `sw_wr`=1 and `sw_flush`=1 while the flush bit is clear sets the flush bit. The bit reads back on `flush_busy` from the next cycle.
- R2: The clock edge that accepts a flush discards every stored byte. `tx_valid` is 0 from the next cycle and stays 0 after the flush completes until a new byte is stored.
- R3: A frame is in flight when the MAC has popped a byte with `tx_sof`=1 and has not yet popped a byte with `tx_eof`=1. If a frame is in flight at the accepting edge, `tx_abort` is 1 for exactly the next cycle and a status word is offered in that same cycle.
- R4: The status word has bit 1 (underflow) = 1 and bit 13 (flushed) = 1, and every other bit 0, giving 32'h0000_2002. `st_valid` stays 1 and `st_word` stays stable until a cycle with `st_ready`=1.
- R5: When a status word is offered, the flush bit clears in the cycle after the `st_valid`/`st_ready` handshake.
- R6: With no frame in flight at the accepting edge, no status word and no abort are produced. The flush bit is 1 for exactly one cycle.
- R7: After a flush, input bytes with `dma_sof`=0 are accepted (`dma_ready`=1) and discarded. The first byte with `dma_sof`=1 ends the discarding, and that byte and the bytes after it are stored.
- R8: While the flush bit is 1, `dma_ready`=0 and `tx_valid`=0.
- R9: Writing 1 while a flush is in progress has no effect, and only one status word is produced. Writing `sw_flush`=0 never has an effect: stored bytes are kept.
- R10: Bytes leave in the order they were stored, each with its `sof`/`eof` bits. `dma_ready` is 0 while DEPTH bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software write strobe for the flush control bit |
| sw_flush | input | 1 | Value written; 1 requests a flush |
| flush_busy | output | 1 | Read-back of the flush control bit |
| dma_valid | input | 1 | DMA byte valid |
| dma_ready | output | 1 | Block accepts a DMA byte |
| dma_data | input | 8 | DMA byte |
| dma_sof | input | 1 | Byte is the first of a frame |
| dma_eof | input | 1 | Byte is the last of a frame |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_ready | input | 1 | MAC takes the byte |
| tx_data | output | 8 | Byte to the MAC |
| tx_sof | output | 1 | First-of-frame marker toward the MAC |
| tx_eof | output | 1 | Last-of-frame marker toward the MAC |
| tx_abort | output | 1 | One-cycle underflow abort of the frame in flight |
| st_valid | output | 1 | Status word offered |
| st_ready | input | 1 | Status word accepted |
| st_word | output | 32 | Status word for the flushed frame |

## Verification
The hardest state to reach is a flush that lands while the MAC holds a partial frame and the status port is back-pressured, with a second flush write arriving during the wait. The table-driven part of the bench stores frames of several lengths. It has the MAC pop a chosen number of bytes before requesting the flush, which covers the cases of no byte taken, part of a frame taken and the whole frame taken. A directed test then holds `st_ready` low for several cycles and writes the flush bit again meanwhile. It checks that the word stays put and that one status word appears and no second one follows.

// File: rtl/tx_flush_pkg.sv
// Package: shared types and constants for the transmit FIFO flush controller.
// Assumes an 8-bit byte lane and a 32-bit status word.
package tx_flush_pkg;

    localparam int DATA_W        = 8;
    localparam int STAT_W        = 32;
    localparam int UNDERFLOW_BIT = 1;
    localparam int FLUSHED_BIT   = 13;

    localparam logic [STAT_W-1:0] FLUSH_STATUS =
        (STAT_W'(1) << UNDERFLOW_BIT) | (STAT_W'(1) << FLUSHED_BIT);

    // One FIFO entry: frame markers plus the byte.
    typedef struct packed {
        logic              sof;
        logic              eof;
        logic [DATA_W-1:0] data;
    } tx_beat_t;

    // Flush sequencer states.
    typedef enum logic [1:0] {
        FL_IDLE   = 2'd0,
        FL_CLOSE  = 2'd1,
        FL_STATUS = 2'd2
    } flush_state_t;

endpackage

// File: rtl/tx_flush_fifo.sv
// Module: tx_flush_fifo
// A synchronous FIFO with a clear input that empties it on the same edge.
// The clear takes priority over push and pop. The storage array has no reset.
// Assumes the caller never relies on a push or pop that is refused by full/empty.
module tx_flush_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int            AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   fill;
    logic          do_push;
    logic          do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (fill == '0);
    assign full    = (fill == FULL_CNT);
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Pointer and fill-level update; clear or reset returns everything to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Storage write; a push on the clearing edge is lost.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/tx_flush_drop.sv
// Module: tx_flush_drop
// Discards input bytes after a flush until a start-of-frame byte is seen.
// Assumes 'accept' is the completed input handshake and 'arm' marks the flush edge.
module tx_flush_drop (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic accept,
    input  logic in_sof,
    output logic store
);

    logic dropping;

    assign store = accept && (!dropping || in_sof);

    // Discard window: opened by a flush, closed by the first start-of-frame byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dropping <= 1'b0;
        end else if (arm) begin
            dropping <= 1'b1;
        end else if (accept && in_sof) begin
            dropping <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_flush_ctrl.sv
// Module: tx_flush_ctrl
// Holds the flush control bit and sequences a flush: it clears the FIFO and
// aborts a frame in flight. For such a frame it offers the status word and waits
// for it to be taken; otherwise the flush completes one cycle later.
// Assumes no pop toward the MAC happens while the flush bit is set.
module tx_flush_ctrl
    import tx_flush_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_flush,
    input  logic              pop,
    input  logic              pop_sof,
    input  logic              pop_eof,
    input  logic              st_ready,
    output logic              busy,
    output logic              start,
    output logic              st_valid,
    output logic [STAT_W-1:0] st_word,
    output logic              abort
);

    flush_state_t state;
    logic         in_frame;

    assign start    = sw_wr && sw_flush && (state == FL_IDLE);
    assign busy     = (state != FL_IDLE);
    assign st_valid = (state == FL_STATUS);
    assign st_word  = st_valid ? FLUSH_STATUS : '0;

    // Track whether the MAC is partway through a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            in_frame <= 1'b0;
        end else if (pop) begin
            if (pop_eof)      in_frame <= 1'b0;
            else if (pop_sof) in_frame <= 1'b1;
        end
    end

    // Flush sequencer: idle, one-cycle close, or wait for the status handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FL_IDLE;
        end else begin
            case (state)
                FL_IDLE:   if (start) state <= in_frame ? FL_STATUS : FL_CLOSE;
                FL_CLOSE:  state <= FL_IDLE;
                FL_STATUS: if (st_ready) state <= FL_IDLE;
                default:   state <= FL_IDLE;
            endcase
        end
    end

    // Underflow abort pulse for the frame cut off by the flush.
    always_ff @(posedge clk) begin
        if (!rst_n) abort <= 1'b0;
        else        abort <= start && in_frame;
    end

endmodule

// File: rtl/tx_fifo_flush.sv
// Module: tx_fifo_flush (top)
// Transmit byte FIFO between the DMA front end and the MAC. It adds a
// software-requested flush, an underflow abort with status write-back, and
// discarding of input until the next start-of-frame byte.
// Assumes the MAC treats tx_abort as the end of the current frame.
module tx_fifo_flush
    import tx_flush_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_flush,
    output logic              flush_busy,
    input  logic              dma_valid,
    output logic              dma_ready,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              dma_sof,
    input  logic              dma_eof,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              tx_abort,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [STAT_W-1:0] st_word
);

    localparam int BEAT_W = $bits(tx_beat_t);

    tx_beat_t wr_beat;
    tx_beat_t rd_beat;
    logic     fifo_empty;
    logic     fifo_full;
    logic     flush_start;
    logic     in_accept;
    logic     in_store;
    logic     out_pop;

    assign wr_beat    = '{sof: dma_sof, eof: dma_eof, data: dma_data};
    assign dma_ready  = !flush_busy && !fifo_full;
    assign in_accept  = dma_valid && dma_ready;
    assign tx_valid   = !fifo_empty && !flush_busy;
    assign out_pop    = tx_valid && tx_ready;
    assign tx_data    = rd_beat.data;
    assign tx_sof     = rd_beat.sof;
    assign tx_eof     = rd_beat.eof;

    tx_flush_fifo #(
        .DEPTH (DEPTH),
        .W     (BEAT_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_start),
        .push  (in_store),
        .wdata (wr_beat),
        .pop   (out_pop),
        .rdata (rd_beat),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    tx_flush_drop u_drop (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (flush_start),
        .accept (in_accept),
        .in_sof (dma_sof),
        .store  (in_store)
    );

    tx_flush_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (sw_wr),
        .sw_flush (sw_flush),
        .pop      (out_pop),
        .pop_sof  (rd_beat.sof),
        .pop_eof  (rd_beat.eof),
        .st_ready (st_ready),
        .busy     (flush_busy),
        .start    (flush_start),
        .st_valid (st_valid),
        .st_word  (st_word),
        .abort    (tx_abort)
    );

endmodule

// File: rtl/tx_fifo_flush_chk.sv
// Module: tx_fifo_flush_chk
// Port-level protocol checks for tx_fifo_flush, attached by bind.
module tx_fifo_flush_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_busy,
    input logic        dma_ready,
    input logic        tx_valid,
    input logic        tx_abort,
    input logic        st_valid,
    input logic        st_ready,
    input logic [31:0] st_word
);

    // R4: the word carries both the underflow and the flushed flag.
    a_r4_status_flags: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_word == 32'h0000_2002));

    // R4: an offered word that is not taken stays offered and unchanged.
    a_r4_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_word)));

    // R5: the flush bit drops after the status handshake.
    a_r5_clear_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> !flush_busy);

    // R3: a status word first appears together with the abort pulse.
    a_r3_abort_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> tx_abort);

    // R2: the FIFO is empty when the flush completes.
    a_r2_empty_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> !tx_valid);

    // R8: both data sides are held off while the flush bit is set.
    a_r8_sides_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (!dma_ready && !tx_valid));

endmodule

bind tx_fifo_flush tx_fifo_flush_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_busy (flush_busy),
    .dma_ready  (dma_ready),
    .tx_valid   (tx_valid),
    .tx_abort   (tx_abort),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_word    (st_word)
);

// File: tb/test_tx_fifo_flush.sv
`timescale 1ns/1ps
module test_tx_fifo_flush;

    localparam int DEPTH = 8;
    localparam int NV    = 6;
    localparam logic [31:0] STAT_EXP = 32'h0000_2002;
    // Vector table: frame length, bytes the MAC pops before the flush, status expected.
    localparam int V_LEN  [NV] = '{4, 4, 4, 1, 6, 3};
    localparam int V_POP  [NV] = '{0, 2, 4, 1, 5, 1};
    localparam int V_STAT [NV] = '{0, 1, 0, 0, 1, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0, sw_flush = 1'b0;
    logic        flush_busy;
    logic        dma_valid = 1'b0, dma_sof = 1'b0, dma_eof = 1'b0;
    logic [7:0]  dma_data = '0;
    logic        dma_ready;
    logic        tx_valid, tx_sof, tx_eof, tx_abort;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        st_valid;
    logic        st_ready = 1'b1;
    logic [31:0] st_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tx_fifo_flush #(.DEPTH(DEPTH)) i_tx_fifo_flush (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_flush(sw_flush),
        .flush_busy(flush_busy), .dma_valid(dma_valid), .dma_ready(dma_ready),
        .dma_data(dma_data), .dma_sof(dma_sof), .dma_eof(dma_eof),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_abort(tx_abort),
        .st_valid(st_valid), .st_ready(st_ready), .st_word(st_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Store one byte; returns at the negedge after the accepting edge.
    task automatic push_byte(input logic [7:0] d, input logic f, input logic l);
        dma_valid = 1'b1; dma_data = d; dma_sof = f; dma_eof = l;
        while (!dma_ready) @(negedge clk);
        @(negedge clk);
        dma_valid = 1'b0; dma_sof = 1'b0; dma_eof = 1'b0;
    endtask

    // MAC takes one byte after checking it.
    task automatic pop_check(input string req, input logic [7:0] d, input logic f, input logic l);
        chk(req, {31'd0, tx_valid}, 32'd1);
        chk(req, {24'd0, tx_data}, {24'd0, d});
        chk(req, {30'd0, tx_sof, tx_eof}, {30'd0, f, l});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic sw_write(input logic v);
        sw_wr = 1'b1; sw_flush = v;
        @(negedge clk);
        sw_wr = 1'b0; sw_flush = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R10)
        chk("R1 reset flush bit", {31'd0, flush_busy}, 32'd0);
        chk("R10 reset ready", {31'd0, dma_ready}, 32'd1);
        chk("R10 reset empty", {31'd0, tx_valid}, 32'd0);
        chk("R4 reset no status", {31'd0, st_valid}, 32'd0);
        chk("R3 reset no abort", {31'd0, tx_abort}, 32'd0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < V_LEN[v]; i++)
                push_byte(8'(16 * v + i), i == 0, i == V_LEN[v] - 1);
            for (int i = 0; i < V_POP[v]; i++)
                pop_check("R10 order", 8'(16 * v + i), i == 0, i == V_LEN[v] - 1);
            sw_write(1'b1);
            chk("R1 flush bit set", {31'd0, flush_busy}, 32'd1);
            chk("R8 out blocked", {31'd0, tx_valid}, 32'd0);
            chk("R8 in blocked", {31'd0, dma_ready}, 32'd0);
            chk("R3 R6 status offered", {31'd0, st_valid}, 32'(V_STAT[v]));
            chk("R3 R6 abort pulse", {31'd0, tx_abort}, 32'(V_STAT[v]));
            if (V_STAT[v] != 0) chk("R4 status word", st_word, STAT_EXP);
            @(negedge clk);
            chk("R5 R6 flush bit cleared", {31'd0, flush_busy}, 32'd0);
            chk("R3 abort one cycle", {31'd0, tx_abort}, 32'd0);
            chk("R2 FIFO emptied", {31'd0, tx_valid}, 32'd0);
            chk("R7 ready while dropping", {31'd0, dma_ready}, 32'd1);
            push_byte(8'hA0, 1'b0, 1'b0);
            push_byte(8'hA1, 1'b0, 1'b1);
            chk("R7 non-sof bytes dropped", {31'd0, tx_valid}, 32'd0);
            push_byte(8'hB0, 1'b1, 1'b0);
            push_byte(8'hB1, 1'b0, 1'b1);
            pop_check("R7 sof restarts storage", 8'hB0, 1'b1, 1'b0);
            pop_check("R7 following byte stored", 8'hB1, 1'b0, 1'b1);
        end

        // Back-pressured status and repeated write (R4, R5, R9)
        push_byte(8'h51, 1'b1, 1'b0);
        push_byte(8'h52, 1'b0, 1'b0);
        push_byte(8'h53, 1'b0, 1'b1);
        pop_check("R10 order", 8'h51, 1'b1, 1'b0);
        st_ready = 1'b0;
        sw_write(1'b1);
        chk("R3 abort on hold", {31'd0, tx_abort}, 32'd1);
        for (int c = 0; c < 3; c++) begin
            if (c == 1) begin
                sw_wr = 1'b1; sw_flush = 1'b1;
            end
            @(negedge clk);
            sw_wr = 1'b0; sw_flush = 1'b0;
            chk("R4 status held", {31'd0, st_valid}, 32'd1);
            chk("R4 word stable", st_word, STAT_EXP);
            chk("R5 bit set until taken", {31'd0, flush_busy}, 32'd1);
            chk("R9 no extra abort", {31'd0, tx_abort}, 32'd0);
        end
        st_ready = 1'b1;
        @(negedge clk);
        chk("R5 cleared after handshake", {31'd0, flush_busy}, 32'd0);
        chk("R9 single status", {31'd0, st_valid}, 32'd0);
        @(negedge clk);
        chk("R9 no second status", {31'd0, st_valid}, 32'd0);
        chk("R9 no second flush", {31'd0, flush_busy}, 32'd0);

        // Writing zero does nothing (R9)
        push_byte(8'h61, 1'b1, 1'b0);
        push_byte(8'h62, 1'b0, 1'b1);
        sw_write(1'b0);
        chk("R9 zero write ignored", {31'd0, flush_busy}, 32'd0);
        pop_check("R9 data kept", 8'h61, 1'b1, 1'b0);
        pop_check("R9 data kept", 8'h62, 1'b0, 1'b1);

        // Full FIFO (R10)
        for (int i = 0; i < DEPTH; i++) push_byte(8'(8'h70 + i), i == 0, i == DEPTH - 1);
        chk("R10 full not ready", {31'd0, dma_ready}, 32'd0);
        for (int i = 0; i < DEPTH; i++)
            pop_check("R10 full drain order", 8'(8'h70 + i), i == 0, i == DEPTH - 1);
        chk("R10 drained", {31'd0, tx_valid}, 32'd0);

        // Full FIFO flushed with no frame in flight (R2, R6)
        for (int i = 0; i < DEPTH; i++) push_byte(8'(8'h80 + i), i == 0, i == DEPTH - 1);
        sw_write(1'b1);
        chk("R6 no status when idle", {31'd0, st_valid}, 32'd0);
        chk("R1 bit set on full flush", {31'd0, flush_busy}, 32'd1);
        @(negedge clk);
        chk("R6 one-cycle flush", {31'd0, flush_busy}, 32'd0);
        chk("R2 full FIFO emptied", {31'd0, tx_valid}, 32'd0);
        chk("R2 space restored", {31'd0, dma_ready}, 32'd1);
        push_byte(8'h90, 1'b1, 1'b1);
        pop_check("R7 sof after full flush", 8'h90, 1'b1, 1'b1);

        finish_run();
    end

endmodule